// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block divides a fast input clock by a modulus chosen from a fixed list of nine values. The output has an exact 50% duty cycle for every modulus, including the odd ones, because the low phase is built from a flop clocked on the rising edge and a flop clocked on the falling edge of the fast clock. Each output cycle starts with a falling edge and ends high. A separate one-fast-cycle strobe marks the start of every output cycle.

An enable input starts and stops the output. A polarity bit sets whether the enable is active high or active low. The enable passes through a two-stage synchronizer. Once the synchronized enable is seen, the next fast edge starts a fresh output cycle. When the enable is withdrawn, the cycle in progress runs to its end, and the output then rests high until the enable returns. The enable is only examined at cycle boundaries, so a withdrawal shorter than one output period can be lost. The modulus select is taken at the same boundaries, so the output never produces a short pulse.

Top module: `gated_clk_div`

## Requirements
- R1: The 4-bit modulus code selects the divide ratio N as follows: 0→3, 1→4, 2→5, 3→6, 4→8, 5→10, 6→12, 7→16, 8→20. Codes 9 to 15 all select 20. While running, one output cycle lasts N fast-clock periods.
- R2: Each output cycle is low for N fast half-periods and then high for N fast half-periods. This gives a 50% duty cycle for odd N as well as even N.
- R3: The enable polarity bit set to 1 makes the enable active high, and set to 0 makes it active low. While the enable is at its inactive level, the output stays high and the strobe stays low.
- R4: With the block idle, the first output cycle starts on the third rising fast-clock edge after the enable becomes active. At that edge the output falls.
- R5: When the enable is withdrawn, the output completes its current cycle and then stays high. No further strobe occurs until the enable is asserted again.
- R6: A withdrawal of the enable that has ended before the next cycle boundary is seen by the block has no effect. The output continues without interruption.
- R7: A change of the modulus code takes effect only from the next cycle boundary. The cycle in progress completes with the old N.
- R8: Immediately after reset the output is high and the strobe is low.
- R9: The strobe is high for exactly one fast-clock period, starting at the rising fast-clock edge at which each output cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkFast | input | 1 | Fast input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| modSel | input | 4 | Modulus select code |
| enPol | input | 1 | Enable polarity: 1 active high, 0 active low |
| enIn | input | 1 | Output enable, asynchronous to the fast clock |
| clkOut | output | 1 | Divided clock, rests high when stopped |
| cycStart | output | 1 | One-fast-cycle strobe at the start of each output cycle |

## Verification
An enable change made just after a rising edge passes through the two synchronizer flops. The output falls and the strobe rises on the third rising edge after the change. After that, the output toggles on whichever fast edge the pattern calls for: rising edges for even moduli, and falling edges as well for odd moduli.

The bench steps in half-period increments, sampling two time units after each fast edge. At half-period index h, counted from the start edge, it expects the output to be low when h mod 2N is below N, and the strobe to be high only in the two half-periods after a start edge. A withdrawal is therefore expected to show high from half-period 2N of the cycle in which it falls. A modulus change made mid-cycle is expected to take effect from the next boundary.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  localparam int SEL_W = 4;
  localparam int MOD_W = 5;

  typedef struct packed {
    logic             load;
    logic             keep;
    logic [MOD_W-1:0] modulus;
  } divCtrl_t;

  function automatic logic [MOD_W-1:0] decodeMod(input logic [SEL_W-1:0] code);
    logic [MOD_W-1:0] m;
    case (code)
      SEL_W'(0): m = MOD_W'(3);
      SEL_W'(1): m = MOD_W'(4);
      SEL_W'(2): m = MOD_W'(5);
      SEL_W'(3): m = MOD_W'(6);
      SEL_W'(4): m = MOD_W'(8);
      SEL_W'(5): m = MOD_W'(10);
      SEL_W'(6): m = MOD_W'(12);
      SEL_W'(7): m = MOD_W'(16);
      default:   m = MOD_W'(20);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] modSel,
  input  logic             enPol,
  input  logic             enIn,
  input  logic             atEnd,
  output divCtrl_t         ctrlOut,
  output logic             cycStart
);

  logic                   activeRaw;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   enSync;
  logic                   runQ;
  logic                   cycStartQ;
  logic                   loadNow;
  logic                   keepNow;

  assign activeRaw = enPol ? enIn : ~enIn;
  assign enSync    = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= activeRaw;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        syncQ[i] <= syncQ[i-1];
      end
    end
  end

  // a new cycle starts when idle and enabled, or at a boundary while enabled
  assign loadNow = enSync & (~runQ | atEnd);
  assign keepNow = runQ & ~atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      cycStartQ <= 1'b0;
    end else begin
      runQ      <= loadNow | keepNow;
      cycStartQ <= loadNow;
    end
  end

  always_comb begin
    ctrlOut.load    = loadNow;
    ctrlOut.keep    = keepNow;
    ctrlOut.modulus = decodeMod(modSel);
  end

  assign cycStart = cycStartQ;

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycStartQ |=> !cycStartQ);

  // R5
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> $past(atEnd));

  // R4
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> cycStartQ);

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  divCtrl_t ctrlIn,
  output logic     atEnd,
  output logic     divOut
);

  logic [MOD_W-1:0] cnt;
  logic [MOD_W-1:0] cntD;
  logic [MOD_W-1:0] modCur;
  logic [MOD_W-1:0] modCurD;
  logic             lowPos;
  logic             lowPosD;
  logic             lowNeg;
  logic             oddQ;

  always_comb begin
    modCurD = ctrlIn.load ? ctrlIn.modulus : modCur;
    if (ctrlIn.load) begin
      cntD = '0;
    end else if (ctrlIn.keep) begin
      cntD = cnt + MOD_W'(1);
    end else begin
      cntD = '0;
    end
    // rising-edge low phase lasts floor(N/2) fast periods
    lowPosD = (ctrlIn.load | ctrlIn.keep) && (cntD < (modCurD >> 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      modCur <= decodeMod(SEL_W'(0));
      lowPos <= 1'b0;
      oddQ   <= 1'b0;
    end else begin
      cnt    <= cntD;
      modCur <= modCurD;
      lowPos <= lowPosD;
      oddQ   <= modCurD[0];
    end
  end

  // falling-edge copy stretches the low phase by half a period for odd N
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      lowNeg <= 1'b0;
    end else begin
      lowNeg <= lowPos & oddQ;
    end
  end

  assign atEnd  = (cnt == modCur - MOD_W'(1));
  assign divOut = ~(lowPos | lowNeg);

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < modCur);

  // R2
  neg_phase_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowNeg |-> oddQ);

  // R7
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modCur) |-> $past(ctrlIn.load));

endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div
  import gcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clkFast,
  input  logic             rstN,
  input  logic [SEL_W-1:0] modSel,
  input  logic             enPol,
  input  logic             enIn,
  output logic             clkOut,
  output logic             cycStart
);

  divCtrl_t ctrlBus;
  logic     atEnd;

  gcd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clkFast),
    .rstN     (rstN),
    .modSel   (modSel),
    .enPol    (enPol),
    .enIn     (enIn),
    .atEnd    (atEnd),
    .ctrlOut  (ctrlBus),
    .cycStart (cycStart)
  );

  gcd_datapath u_datapath (
    .clk    (clkFast),
    .rstN   (rstN),
    .ctrlIn (ctrlBus),
    .atEnd  (atEnd),
    .divOut (clkOut)
  );

endmodule

// File: tb/gated_clk_div_bench.sv
module gated_clk_div_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NEVER      = 1 << 30;

  logic       clkFast = 1'b0;
  logic       rstN    = 1'b0;
  logic [3:0] modSel  = 4'd0;
  logic       enPol   = 1'b0;
  logic       enIn    = 1'b1;
  logic       clkOut;
  logic       cycStart;

  int checks = 0;
  int errors = 0;

  gated_clk_div u_gated_clk_div (
    .clkFast  (clkFast),
    .rstN     (rstN),
    .modSel   (modSel),
    .enPol    (enPol),
    .enIn     (enIn),
    .clkOut   (clkOut),
    .cycStart (cycStart)
  );

  always #(HALF) clkFast = ~clkFast;

  // R1: ratio table from the requirement
  function automatic int expMod(input int code);
    case (code)
      0: return 3;
      1: return 4;
      2: return 5;
      3: return 6;
      4: return 8;
      5: return 10;
      6: return 12;
      7: return 16;
      default: return 20;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Walks half-periods h0..h0+count-1, one sample per half-period.
  task automatic span(input string req, input int n1, input int switchH, input int n2,
                      input int parkFrom, input int h0, input int count);
    int badO = -1;
    int badS = -1;
    int actO = 0;
    int expO = 0;
    int actS = 0;
    int expS = 0;
    for (int h = h0; h < h0 + count; h++) begin
      int eo;
      int es;
      int rel;
      int relp;
      int nn;
      if (h >= parkFrom) begin
        eo = 1;
        es = 0;
      end else begin
        if (h < switchH) begin
          rel = h;
          nn  = n1;
        end else begin
          rel = h - switchH;
          nn  = n2;
        end
        relp = rel - (rel % 2);
        eo = ((rel % (2 * nn)) >= nn) ? 1 : 0;
        es = ((relp % (2 * nn)) == 0) ? 1 : 0;
      end
      if (badO < 0 && int'(clkOut) != eo) begin
        badO = h;
        actO = int'(clkOut);
        expO = eo;
      end
      if (badS < 0 && int'(cycStart) != es) begin
        badS = h;
        actS = int'(cycStart);
        expS = es;
      end
      #(HALF);
    end
    check(req, $sformatf("clkOut first bad half %0d", badO), actO, expO);
    check(req, $sformatf("cycStart first bad half %0d", badS), actS, expS);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rstN = 1'b1;
    #1;
    // R8
    check("R8", "clkOut after reset", int'(clkOut), 1);
    check("R8", "cycStart after reset", int'(cycStart), 0);
    @(posedge clkFast);
    #2;

    for (int code = 0; code < 16; code++) begin
      int  n;
      logic pol;
      n     = expMod(code);
      pol   = (code % 2) == 1;
      enPol = pol;
      enIn  = pol ? 1'b0 : 1'b1;
      modSel = 4'(code);
      // R3: inactive level of the chosen polarity keeps the output parked
      span("R3", 1, NEVER, 1, 0, 0, 44);
      enIn = pol ? 1'b1 : 1'b0;
      repeat (3) @(posedge clkFast);
      #2;
      // R1 R2 R4 R9: three full cycles starting at the third edge
      span($sformatf("R1 R2 R4 R9 code %0d", code), n, NEVER, n, NEVER, 0, 6 * n);
      enIn = pol ? 1'b0 : 1'b1;
      // R5: withdrawal at the start of cycle four, finish it then park
      span($sformatf("R5 code %0d", code), n, NEVER, n, 8 * n, 6 * n, 4 * n);
    end

    // R7: switch from ratio 3 to ratio 20 in mid-cycle
    enPol  = 1'b0;
    enIn   = 1'b1;
    modSel = 4'd0;
    span("R3", 1, NEVER, 1, 0, 0, 20);
    enIn = 1'b0;
    repeat (3) @(posedge clkFast);
    #2;
    span("R7", 3, 6, 20, NEVER, 0, 1);
    modSel = 4'd8;
    span("R7", 3, 6, 20, NEVER, 1, 85);
    enIn = 1'b1;
    span("R7 R5", 3, 6, 20, 126, 86, 60);

    // R6: one-cycle withdrawal well inside a ratio-20 cycle
    enIn = 1'b0;
    repeat (3) @(posedge clkFast);
    #2;
    span("R6", 20, NEVER, 20, NEVER, 0, 4);
    enIn = 1'b1;
    span("R6", 20, NEVER, 20, NEVER, 4, 2);
    enIn = 1'b0;
    span("R6", 20, NEVER, 20, NEVER, 6, 114);
    enIn = 1'b1;
    span("R6 R5", 20, NEVER, 20, 160, 120, 60);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule